// File: doc/BRIEF.md
# Read Delay Window Training Sequencer

This block trains the programmable read-capture delay lines of a memory data path. For each lane it walks the delay tap upward from a lower bound. After every tap change it applies the new tap, waits for the line to settle, writes a tap-dependent test word to memory and reads it back. It compares only the bits that belong to the lane under training. It records the first contiguous run of passing taps and then programs the lane with the middle of that run.

A lane is one byte of the data bus in wide-device mode, or one nibble in narrow-device mode. The mode is sampled when training starts. Lanes are trained one after another. While training runs, a hold output keeps the automatic delay calibration from overwriting the taps. A lane that never passes keeps its earlier tap and raises its error flag. Every tap update, whether during the sweep or at the final commit, is followed by a load strobe, and the delay line only uses a new tap when it sees that strobe.

Top module: `rd_window_trainer`

## Requirements
- R1: `cal_hold` is high from the cycle after `start` is accepted until training ends, is low while idle and in the `done` cycle, and no memory request is issued while it is low.
- R2: For each lane the tap runs upward by one from `MIN_TAP`, one memory write per tap. The sweep stops at `MAX_TAP`, or at the first failing tap that follows a pass.
- R3: Each tap visit follows a fixed order. `tap_load` pulses for one cycle, then `SETTLE` idle cycles pass, then `mem_wr` is high for one cycle, and `mem_rd` is high in the next cycle. Every byte of `mem_wdata` equals the tap XOR `PATTERN`.
- R4: Only the bits of the lane under training decide pass or fail. Mismatches in other bits are ignored.
- R5: With `narrow_mode`=0 there are `NB` lanes, and lane l drives nibble taps 2l and 2l+1 together (tap bits [8n+7:8n] belong to nibble n, which covers data bits [4n+3:4n]). With `narrow_mode`=1 there are 2·`NB` lanes, and lane l is nibble l.
- R6: `tap_out` never changes in a cycle without `tap_load` high, and the delay line is expected to use only the value present at `tap_load`.
- R7: A lane with a passing run ends with its tap(s) at floor((lowest + highest passing tap) / 2).
- R8: The window is the first contiguous passing run. A pass that appears after a failing tap beyond that run has no effect on the result.
- R9: A lane with no passing tap sets its `lane_err` bit(s) and keeps its tap(s) at the value held before that run.
- R10: Lanes are trained in ascending order. `done` is a single-cycle pulse after the last lane, and `lane_err` is cleared when a new run starts.
- R11: After reset all taps equal `DEF_TAP`, and `lane_err`, `done`, `cal_hold`, `tap_load`, `mem_wr` and `mem_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a training run when idle |
| narrow_mode | input | 1 | 1: nibble lanes, 0: byte lanes |
| cal_hold | output | 1 | Holds off automatic calibration while training |
| done | output | 1 | One-cycle end-of-training pulse |
| tap_load | output | 1 | Apply strobe for the current tap outputs |
| tap_out | output | 16·NB | One TAP_W-bit tap per nibble |
| mem_wr | output | 1 | Test write request |
| mem_rd | output | 1 | Test read request |
| mem_wdata | output | 8·NB | Test write data |
| mem_rdata | input | 8·NB | Read-back data |
| mem_rvalid | input | 1 | Read-back data valid |
| lane_err | output | 2·NB | Per-nibble no-window flag |

## Verification
The bench builds the block with `NB`=2, `MAX_TAP`=40, `SETTLE`=3 and `DEF_TAP`=0x11. The short tap range makes three cases cheap to reach: a window that runs up to the top tap, a lane that fails over its whole sweep, and a window that starts at tap 0. With two bytes there are four nibbles, so the byte-to-nibble-pair mapping is exercised. That includes a byte whose two nibble windows do not overlap. The memory model corrupts each nibble according to the tap last loaded for it, so a missing load strobe, a stale tap or a wrong lane mask all show up in the programmed results.

// File: rtl/trn_pkg.sv
package trn_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_WR,
    ST_RD,
    ST_WAIT,
    ST_COMMIT,
    ST_CLOAD,
    ST_DONE
  } trn_state_e;
endpackage

// File: rtl/trn_lane_sel.sv
module trn_lane_sel #(
  parameter int NB     = 2,
  parameter int LANE_W = 2
) (
  input  logic [LANE_W-1:0] lane,
  input  logic              narrow,
  output logic [2*NB-1:0]   nib_sel,
  output logic [8*NB-1:0]   bit_mask
);
  localparam int NNIB = 2 * NB;

  for (genvar n = 0; n < NNIB; n++) begin : g_nib
    localparam logic [LANE_W-1:0] NIDX = LANE_W'(n);
    localparam logic [LANE_W-1:0] BIDX = LANE_W'(n / 2);
    assign nib_sel[n]          = narrow ? (lane == NIDX) : (lane == BIDX);
    assign bit_mask[4*n +: 4]  = {4{nib_sel[n]}};
  end
endmodule

// File: rtl/trn_window.sv
module trn_window #(
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic             found,
  output logic [TAP_W-1:0] lo,
  output logic [TAP_W-1:0] hi,
  output logic [TAP_W-1:0] centre
);
  logic             found_d;
  logic [TAP_W-1:0] lo_d, hi_d;
  logic [TAP_W:0]   sum;

  always_comb begin
    found_d = found;
    lo_d    = lo;
    hi_d    = hi;
    if (clear) begin
      found_d = 1'b0;
    end else if (upd && pass) begin
      found_d = 1'b1;
      hi_d    = tap;
      if (!found) lo_d = tap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found <= 1'b0;
      lo    <= '0;
      hi    <= '0;
    end else begin
      found <= found_d;
      lo    <= lo_d;
      hi    <= hi_d;
    end
  end

  assign sum    = {1'b0, lo} + {1'b0, hi};
  assign centre = sum[TAP_W:1];

  p_lo_le_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (lo <= hi));
  p_centre_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (centre >= lo && centre <= hi));
endmodule

// File: rtl/rd_window_trainer.sv
module rd_window_trainer #(
  parameter int         NB      = 2,
  parameter int         TAP_W   = 8,
  parameter int         MIN_TAP = 0,
  parameter int         MAX_TAP = 255,
  parameter int         SETTLE  = 8,
  parameter int         DEF_TAP = 64,
  parameter logic [7:0] PATTERN = 8'h5A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  narrow_mode,
  output logic                  cal_hold,
  output logic                  done,
  output logic                  tap_load,
  output logic [2*NB*TAP_W-1:0] tap_out,
  output logic                  mem_wr,
  output logic                  mem_rd,
  output logic [8*NB-1:0]       mem_wdata,
  input  logic [8*NB-1:0]       mem_rdata,
  input  logic                  mem_rvalid,
  output logic [2*NB-1:0]       lane_err
);
  import trn_pkg::*;

  localparam int               NNIB   = 2 * NB;
  localparam int               LANE_W = (NNIB > 1) ? $clog2(NNIB) : 1;
  localparam int               CNT_W  = $clog2(SETTLE + 1);
  localparam logic [TAP_W-1:0] MIN_T  = TAP_W'(MIN_TAP);
  localparam logic [TAP_W-1:0] MAX_T  = TAP_W'(MAX_TAP);
  localparam logic [TAP_W-1:0] DEF_T  = TAP_W'(DEF_TAP);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE - 1);
  localparam logic [LANE_W-1:0] LAST_NIB  = LANE_W'(NNIB - 1);
  localparam logic [LANE_W-1:0] LAST_BYTE = LANE_W'(NB - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  trn_state_e        state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              mode_q, mode_d;
  logic [TAP_W-1:0]  commit_q [NNIB];
  logic [NNIB-1:0]   err_q;

  logic [NNIB-1:0]   nib_sel;
  logic [8*NB-1:0]   bit_mask;
  logic              win_found;
  logic [TAP_W-1:0]  win_lo, win_hi, win_centre;
  logic              lane_pass, win_upd, win_clr, end_sweep, last_lane;
  logic              sweeping, commit_en, run_start;

  trn_lane_sel #(.NB(NB), .LANE_W(LANE_W)) i_sel (
    .lane(lane_q), .narrow(mode_q), .nib_sel(nib_sel), .bit_mask(bit_mask)
  );

  trn_window #(.TAP_W(TAP_W)) i_win (
    .clk(clk), .rst_n(rst_q_n), .clear(win_clr), .upd(win_upd),
    .pass(lane_pass), .tap(tap_q), .found(win_found), .lo(win_lo),
    .hi(win_hi), .centre(win_centre)
  );

  assign mem_wdata = {NB{tap_q[7:0] ^ PATTERN}};
  assign lane_pass = ((mem_rdata ^ mem_wdata) & bit_mask) == '0;
  assign win_upd   = (state_q == ST_WAIT) && mem_rvalid;
  assign win_clr   = (state_q == ST_IDLE) || (state_q == ST_CLOAD);
  assign end_sweep = (tap_q == MAX_T) || (win_found && !lane_pass);
  assign last_lane = mode_q ? (lane_q == LAST_NIB) : (lane_q == LAST_BYTE);
  assign run_start = (state_q == ST_IDLE) && start;
  assign commit_en = (state_q == ST_COMMIT);
  assign sweeping  = (state_q == ST_LOAD) || (state_q == ST_SETTLE) ||
                     (state_q == ST_WR) || (state_q == ST_RD) ||
                     (state_q == ST_WAIT) || (state_q == ST_COMMIT);

  // next-state logic
  always_comb begin
    state_d = state_q;
    lane_d  = lane_q;
    tap_d   = tap_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_LOAD;
        lane_d  = '0;
        tap_d   = MIN_T;
        mode_d  = narrow_mode;
      end
      ST_LOAD: begin
        cnt_d   = '0;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cnt_q == SET_LAST) state_d = ST_WR;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_WR: state_d = ST_RD;
      ST_RD: state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        if (end_sweep) begin
          state_d = ST_COMMIT;
        end else begin
          tap_d   = tap_q + 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_COMMIT: state_d = ST_CLOAD;
      ST_CLOAD: begin
        if (last_lane) begin
          state_d = ST_DONE;
        end else begin
          lane_d  = lane_q + 1'b1;
          tap_d   = MIN_T;
          state_d = ST_LOAD;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      tap_q   <= '0;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      tap_q   <= tap_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  // committed taps and error flags, one set per nibble
  for (genvar n = 0; n < NNIB; n++) begin : g_tap
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        commit_q[n] <= DEF_T;
        err_q[n]    <= 1'b0;
      end else if (run_start) begin
        err_q[n]    <= 1'b0;
      end else if (commit_en && nib_sel[n]) begin
        if (win_found) commit_q[n] <= win_centre;
        else           err_q[n]    <= 1'b1;
      end
    end
    assign tap_out[TAP_W*n +: TAP_W] = (sweeping && nib_sel[n]) ? tap_q : commit_q[n];
  end

  assign lane_err = err_q;
  assign tap_load = (state_q == ST_LOAD) || (state_q == ST_CLOAD);
  assign mem_wr   = (state_q == ST_WR);
  assign mem_rd   = (state_q == ST_RD);
  assign done     = (state_q == ST_DONE);
  assign cal_hold = (state_q != ST_IDLE) && (state_q != ST_DONE);

  p_req_in_hold_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_wr || mem_rd) |-> cal_hold);
  p_tap_in_range_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_wr |-> (tap_q >= MIN_T && tap_q <= MAX_T));
  p_rd_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_rd |-> $past(mem_wr));
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({mem_wr, mem_rd, tap_load, done}));
  p_lane_cover_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    cal_hold |-> ($countones(nib_sel) == (mode_q ? 1 : 2)));
  p_tap_move_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tap_out != $past(tap_out)) |-> tap_load);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done);
endmodule

// File: tb/test_rd_window_trainer.sv
module test_rd_window_trainer;
  localparam int NB = 2, NNIB = 4, TAP_W = 8;
  localparam int MIN_TAP = 0, MAX_TAP = 40, SETTLE = 3, DEF_TAP = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, narrow_mode = 1'b0;
  logic cal_hold, done, tap_load, mem_wr, mem_rd;
  logic [NNIB*TAP_W-1:0] tap_out;
  logic [8*NB-1:0] mem_wdata;
  logic [8*NB-1:0] mem_rdata = '0;
  logic mem_rvalid = 1'b0;
  logic [NNIB-1:0] lane_err;

  always #2.5 clk = ~clk;

  rd_window_trainer #(.NB(NB), .TAP_W(TAP_W), .MIN_TAP(MIN_TAP), .MAX_TAP(MAX_TAP),
    .SETTLE(SETTLE), .DEF_TAP(DEF_TAP), .PATTERN(8'h5A)) i_rd_window_trainer (
    .clk(clk), .rst_n(rst_n), .start(start), .narrow_mode(narrow_mode),
    .cal_hold(cal_hold), .done(done), .tap_load(tap_load), .tap_out(tap_out),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .lane_err(lane_err));

  int total = 0, bad = 0;
  int wlo [NNIB], whi [NNIB], wiso [NNIB];
  int loaded [NNIB];
  int exp_tap [NNIB];
  logic [NNIB-1:0] exp_err;
  int exp_writes;
  int wr_cnt = 0, gap = 0, gap_viol = 0, pat_viol = 0, hold_viol = 0, move_viol = 0;
  logic [8*NB-1:0] store = '0;
  logic rd_pend = 1'b0;
  logic [NNIB*TAP_W-1:0] prev_tap = '0;
  logic mon_on = 1'b0;

  task automatic check(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit pass_nib(int n, int t);
    return (t >= wlo[n] && t <= whi[n]) || t == wiso[n];
  endfunction

  // behavioural delay line + memory: a nibble reads back inverted unless its
  // last loaded tap lies in its pass window
  always @(negedge clk) begin
    if (mon_on) begin
      if (tap_load) begin
        for (int n = 0; n < NNIB; n++) loaded[n] = int'(tap_out[8*n +: 8]);
        gap = 0;
      end else begin
        gap++;
      end
      if (tap_out != prev_tap && !tap_load) move_viol++;
      prev_tap = tap_out;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        logic [8*NB-1:0] c;
        c = '0;
        for (int n = 0; n < NNIB; n++) if (!pass_nib(n, loaded[n])) c[4*n +: 4] = 4'hF;
        mem_rdata  = store ^ c;
        mem_rvalid = 1'b1;
        rd_pend    = 1'b0;
      end
      if (mem_rd) rd_pend = 1'b1;
      if ((mem_wr || mem_rd) && !cal_hold) hold_viol++;
      if (mem_wr) begin
        wr_cnt++;
        store = mem_wdata;
        if (gap != SETTLE + 1) gap_viol++;
        if (mem_wdata[15:8] != mem_wdata[7:0]) pat_viol++;
      end
    end
  end

  function automatic void predict(bit narrow);
    int nl;
    nl = narrow ? NNIB : NB;
    exp_writes = 0;
    exp_err = '0;
    for (int l = 0; l < nl; l++) begin
      bit found; int lo, hi, sw; bit p;
      found = 0; lo = 0; hi = 0; sw = 0;
      for (int t = MIN_TAP; t <= MAX_TAP; t++) begin
        sw++;
        p = narrow ? pass_nib(l, t) : (pass_nib(2*l, t) && pass_nib(2*l+1, t));
        if (p) begin
          if (!found) lo = t;
          found = 1; hi = t;
        end else if (found) break;
      end
      exp_writes += sw;
      for (int n = 0; n < NNIB; n++) begin
        if ((narrow && n == l) || (!narrow && n / 2 == l)) begin
          if (found) exp_tap[n] = (lo + hi) / 2;
          else       exp_err[n] = 1'b1;
        end
      end
    end
  endfunction

  task automatic run_training(bit narrow, string tag);
    int guard;
    predict(narrow);
    wr_cnt = 0; gap_viol = 0; pat_viol = 0; hold_viol = 0; move_viol = 0;
    @(negedge clk);
    narrow_mode = narrow; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1", int'(cal_hold), 1, {tag, " hold raised after start"});
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    check("R10", int'(done), 1, {tag, " done seen"});
    check("R1", int'(cal_hold), 0, {tag, " hold low at done"});
    check("R2", wr_cnt, exp_writes, {tag, " taps swept (write count)"});
    check("R3", gap_viol, 0, {tag, " load-settle-write spacing violations"});
    check("R3", pat_viol, 0, {tag, " pattern bytes differ"});
    check("R1", hold_viol, 0, {tag, " requests outside hold"});
    check("R6", move_viol, 0, {tag, " tap change without load"});
    for (int n = 0; n < NNIB; n++) begin
      check("R7", int'(tap_out[8*n +: 8]), exp_tap[n], $sformatf("%s tap nibble %0d", tag, n));
      check("R9", int'(lane_err[n]), int'(exp_err[n]), $sformatf("%s err nibble %0d", tag, n));
    end
    @(negedge clk);
    check("R10", int'(done), 0, {tag, " done is one cycle"});
  endtask

  task automatic set_win(int n, int lo, int hi, int iso);
    wlo[n] = lo; whi[n] = hi; wiso[n] = iso;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int n = 0; n < NNIB; n++) begin
      exp_tap[n] = DEF_TAP; loaded[n] = DEF_TAP;
      check("R11", int'(tap_out[8*n +: 8]), DEF_TAP, $sformatf("reset tap nibble %0d", n));
    end
    check("R11", int'(lane_err), 0, "reset err flags");
    check("R11", int'({done, cal_hold, tap_load, mem_wr, mem_rd}), 0, "reset strobes");
    prev_tap = tap_out;
    mon_on = 1'b1;
  endtask

  // R4/R5 byte lanes with overlapping nibble windows; other lane bits corrupt
  task automatic t_byte_basic;
    set_win(0, 10, 20, 255); set_win(1, 12, 25, 255);
    set_win(2, 3, 30, 255);  set_win(3, 4, 33, 255);
    run_training(1'b0, "R5 byte basic");
  endtask

  // R8 isolated later pass, window at top tap, R9 empty lane, window at tap 0
  task automatic t_nibble_edges;
    set_win(0, 5, 9, 20);    set_win(1, 35, 40, 255);
    set_win(2, 200, 200, 255); set_win(3, 0, 0, 255);
    run_training(1'b1, "R8 nibble edges");
  endtask

  // R9 byte with disjoint nibble windows keeps earlier taps; R10 flags cleared
  task automatic t_byte_disjoint;
    set_win(0, 2, 6, 255);   set_win(1, 10, 14, 255);
    set_win(2, 20, 21, 255); set_win(3, 21, 30, 255);
    run_training(1'b0, "R9 byte disjoint");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < NNIB; n++) set_win(n, 255, 255, 255);
    t_reset();
    t_byte_basic();
    t_nibble_edges();
    t_byte_disjoint();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule